// File: doc/BRIEF.md
# Triggered Trace Capture Sequencer

This block records a stream of 36-bit received words into a 2048-entry circular trace memory under control of a four-state sequencer. Once the host arms it, every incoming word is written at a free-running address. A trigger fires either when the received word, extended by one external input bit, matches a three-valued pattern (each bit must be 0, must be 1, or is ignored), or when the host issues a force command. After the trigger the block keeps writing for a host-chosen number of words. That number counts the trigger word itself, so the host decides where in the trace the trigger word lands. The block then stops.

The memory address of the trigger word is latched for the host. A 48-bit counter counts words from the trigger onward and freezes once capture ends. In error-counting mode the trace wraps with no length limit. An external error flag can optionally stop the run exactly 15 words after the errored word, which keeps the errored word and what follows it in the trace. The host can abort or soft-reset at any time. A soft reset keeps the trace contents.

Host commands arrive as level bits that do not clear themselves. The block acts on the rising edge of each bit only, so holding a bit high acts once.

Top module: `trace_capture_seq`

## Requirements
- R1: After hardware reset `seq_state` is 0 (idle), and `word_count` and `trig_addr` are 0. The state codes are 0 idle, 1 armed, 2 running, 3 stopped.
- R2: A rising edge of `cmd_arm` in the idle state moves the sequencer to armed on the next cycle. In any other state the edge is ignored. A level held high acts only once.
- R3: While armed, a trigger fires when, for every bit i from 0 to 36, either `trig_mask[i]` is 1 or bit i of {`ext_trig`, `rx_word`} equals `trig_pat[i]`. Bit 36 is the external input.
- R4: While armed, a rising edge of `cmd_force` fires the trigger regardless of the pattern. A force level that is still high after a later re-arm does not fire again.
- R5: On arming, writes start at address 0 and write one word per cycle with the address incrementing modulo 2048. `trig_addr` holds the address at which the trigger word was written.
- R6: In recording mode (`cfg_err_mode`=0) exactly N = `post_len` words are written starting with the trigger word, and the state becomes stopped right after the N-th word. Values below 2 act as 2.
- R7: `word_count` stays 0 before the trigger. It counts every word written from the trigger word onward and does not change while the state is stopped.
- R8: In error mode (`cfg_err_mode`=1) running has no length limit and the write address wraps past 2047 to 0.
- R9: In error mode with `cfg_stop_on_err`=1, a high `err_flag` while running writes that word and 15 more words, and the state then becomes stopped.
- R10: A rising edge of `cmd_abort` in armed or running moves the state to stopped on the next cycle. The abort takes precedence over a trigger firing in the same cycle.
- R11: A rising edge of `cmd_reset` returns the state to idle and clears `word_count` and `trig_addr`. The trace memory contents are kept.
- R12: `rd_data` presents the memory word at `rd_addr` one cycle after the address is applied.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Received-word clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| rx_word | input | 36 | Received word, one per cycle |
| ext_trig | input | 1 | External trigger bit (pattern bit 36) |
| cfg_err_mode | input | 1 | 0 recording mode, 1 error-counting mode |
| cfg_stop_on_err | input | 1 | Stop 15 words after an error (error mode) |
| trig_pat | input | 37 | Trigger pattern |
| trig_mask | input | 37 | Trigger mask, 1 = ignore bit |
| post_len | input | 11 | Words to record from the trigger word on |
| cmd_arm | input | 1 | Arm command level |
| cmd_force | input | 1 | Force-trigger command level |
| cmd_abort | input | 1 | Abort command level |
| cmd_reset | input | 1 | Soft reset command level |
| err_flag | input | 1 | Error seen on the current word |
| rd_addr | input | 11 | Trace read address |
| rd_data | output | 36 | Trace read data (one cycle latency) |
| seq_state | output | 2 | Sequencer state code |
| trig_addr | output | 11 | Address of the trigger word |
| word_count | output | 48 | Words received since the trigger |

## Verification
The collision of interest is an abort command that arrives in the same cycle as the registered trigger decision for the preceding matching word. The bench provokes it by presenting a matching word and raising the abort level on the very next cycle. The expected result is a stopped state with a zero word count and an unchanged trigger address, which shows that the abort won. A second overlap is the last word of the error tail: the bench checks that the state is still running one cycle before the tail ends and stopped exactly after it.

// File: rtl/tcs_pkg.sv
package tcs_pkg;
  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_RUN   = 2'd2,
    ST_STOP  = 2'd3
  } seq_state_t;
endpackage

// File: rtl/tcs_edge.sv
module tcs_edge #(
  parameter int NB = 4
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [NB-1:0] lvl,
  output logic [NB-1:0] rise
);
  for (genvar g = 0; g < NB; g++) begin : g_bit
    logic prev_q;
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) prev_q <= 1'b0;
      else        prev_q <= lvl[g];
    end
    assign rise[g] = lvl[g] & ~prev_q;

    // R2 / R4: a held command level produces a single pulse
    p_single_pulse_r2: assert property (@(posedge clk) disable iff (!rst_n)
      rise[g] |=> !rise[g]);
  end
endmodule

// File: rtl/tcs_match.sv
module tcs_match #(
  parameter int DW = 36
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        armed,
  input  logic        force_e,
  input  logic [DW-1:0] word,
  input  logic        ext,
  input  logic [DW:0] pat,
  input  logic [DW:0] msk,
  output logic        fire
);
  logic [DW:0] probe;
  logic        hit;

  always_comb begin
    probe = {ext, word};
    hit   = &((~(probe ^ pat)) | msk);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) fire <= 1'b0;
    else        fire <= armed & (hit | force_e);
  end

  // R3: a trigger decision only exists for a word sampled while armed
  p_fire_armed_r3: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> $past(armed));
endmodule

// File: rtl/tcs_mem.sv
module tcs_mem #(
  parameter int AW = 11,
  parameter int DW = 36
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [DW-1:0] wr_data,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] store [DEPTH];

  always_ff @(posedge clk) begin
    if (wr_en) store[wr_addr] <= wr_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rd_data <= '0;
    else        rd_data <= store[rd_addr];
  end
endmodule

// File: rtl/tcs_seq.sv
module tcs_seq
  import tcs_pkg::*;
#(
  parameter int AW   = 11,
  parameter int CW   = 48,
  parameter int TAIL = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          e_arm,
  input  logic          e_abort,
  input  logic          e_reset,
  input  logic          fire,
  input  logic          mode_err,
  input  logic          stop_on_err,
  input  logic          err_in,
  input  logic [AW-1:0] post_len,
  output seq_state_t    state,
  output logic          wr_en,
  output logic [AW-1:0] wr_addr,
  output logic [AW-1:0] trig_pos,
  output logic [CW-1:0] word_cnt,
  output logic          armed
);
  localparam int TW = $clog2(TAIL + 1);
  localparam logic [AW-1:0] MIN_LEN = AW'(2);

  seq_state_t    st_q, st_d;
  logic [AW-1:0] ptr_q, ptr_d, tpos_q, tpos_d, left_q, left_d, len_eff;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          pend_q, pend_d, wr_act;
  logic [TW-1:0] eleft_q, eleft_d;

  always_comb begin
    len_eff = (post_len < MIN_LEN) ? MIN_LEN : post_len;
    wr_act  = (st_q == ST_ARMED) || (st_q == ST_RUN);
    st_d    = st_q;
    ptr_d   = wr_act ? ptr_q + AW'(1) : ptr_q;
    tpos_d  = tpos_q;
    left_d  = left_q;
    pend_d  = pend_q;
    eleft_d = eleft_q;
    cnt_d   = cnt_q;
    if (e_reset) begin
      st_d    = ST_IDLE;
      ptr_d   = '0;
      tpos_d  = '0;
      left_d  = '0;
      eleft_d = '0;
      cnt_d   = '0;
    end else begin
      case (st_q)
        ST_IDLE: if (e_arm) st_d = ST_ARMED;
        ST_ARMED: begin
          if (e_abort) st_d = ST_STOP;
          else if (fire) begin
            tpos_d = ptr_q - AW'(1);
            cnt_d  = cnt_q + CW'(2);
            left_d = len_eff - MIN_LEN;
            st_d   = (!mode_err && len_eff == MIN_LEN) ? ST_STOP : ST_RUN;
          end
        end
        ST_RUN: begin
          cnt_d = cnt_q + CW'(1);
          if (e_abort) st_d = ST_STOP;
          else if (mode_err) begin
            if (pend_q) begin
              eleft_d = eleft_q - TW'(1);
              if (eleft_q == TW'(1)) st_d = ST_STOP;
            end else if (stop_on_err && err_in) begin
              pend_d  = 1'b1;
              eleft_d = TW'(TAIL);
            end
          end else begin
            left_d = left_q - AW'(1);
            if (left_q == AW'(1)) st_d = ST_STOP;
          end
        end
        default: ;
      endcase
    end
    if (st_d != ST_RUN) pend_d = 1'b0;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q    <= ST_IDLE;
      ptr_q   <= '0;
      tpos_q  <= '0;
      left_q  <= '0;
      pend_q  <= 1'b0;
      eleft_q <= '0;
      cnt_q   <= '0;
    end else begin
      st_q    <= st_d;
      ptr_q   <= ptr_d;
      tpos_q  <= tpos_d;
      left_q  <= left_d;
      pend_q  <= pend_d;
      eleft_q <= eleft_d;
      cnt_q   <= cnt_d;
    end
  end

  assign state    = st_q;
  assign wr_en    = wr_act;
  assign wr_addr  = ptr_q;
  assign trig_pos = tpos_q;
  assign word_cnt = cnt_q;
  assign armed    = (st_q == ST_ARMED);

  // R2: armed is entered only from idle
  p_arm_from_idle_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q != ST_ARMED) |=> (st_q != ST_ARMED || $past(st_q) == ST_IDLE));
  // R7: nothing is counted before the trigger
  p_cnt_zero_pre_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE || st_q == ST_ARMED) |-> (cnt_q == '0));
  // R7: counter and write address frozen once stopped
  p_frozen_stop_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_STOP && !e_reset) |=> ($stable(cnt_q) && $stable(ptr_q)));
  // R5: trigger address is held while running
  p_tpos_hold_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_RUN && !e_reset) |=> $stable(tpos_q));
  // R9: an error tail only exists while running
  p_tail_run_r9: assert property (@(posedge clk) disable iff (!rst_n)
    pend_q |-> (st_q == ST_RUN));
  // R10: abort reaches stopped in one cycle
  p_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (e_abort && !e_reset && (st_q == ST_ARMED || st_q == ST_RUN)) |=> (st_q == ST_STOP));
endmodule

// File: rtl/trace_capture_seq.sv
module trace_capture_seq
  import tcs_pkg::*;
#(
  parameter int AW   = 11,
  parameter int DW   = 36,
  parameter int CW   = 48,
  parameter int TAIL = 15
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic [DW-1:0] rx_word,
  input  logic          ext_trig,
  input  logic          cfg_err_mode,
  input  logic          cfg_stop_on_err,
  input  logic [DW:0]   trig_pat,
  input  logic [DW:0]   trig_mask,
  input  logic [AW-1:0] post_len,
  input  logic          cmd_arm,
  input  logic          cmd_force,
  input  logic          cmd_abort,
  input  logic          cmd_reset,
  input  logic          err_flag,
  input  logic [AW-1:0] rd_addr,
  output logic [DW-1:0] rd_data,
  output logic [1:0]    seq_state,
  output logic [AW-1:0] trig_addr,
  output logic [CW-1:0] word_count
);
  localparam int NCMD = 4;

  logic [1:0]      rst_sync_q;
  logic            rst_s;
  logic [NCMD-1:0] cmd_rise;
  logic            fire, armed, wr_en;
  logic [AW-1:0]   wr_addr;
  seq_state_t      st;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_sync_q <= 2'b00;
    else        rst_sync_q <= {rst_sync_q[0], 1'b1};
  end
  assign rst_s = rst_sync_q[1];

  tcs_edge #(.NB(NCMD)) u_edge (
    .clk (clk), .rst_n (rst_s),
    .lvl ({cmd_reset, cmd_abort, cmd_force, cmd_arm}),
    .rise(cmd_rise)
  );

  tcs_match #(.DW(DW)) u_match (
    .clk (clk), .rst_n (rst_s), .armed (armed), .force_e (cmd_rise[1]),
    .word(rx_word), .ext (ext_trig), .pat (trig_pat), .msk (trig_mask),
    .fire(fire)
  );

  tcs_seq #(.AW(AW), .CW(CW), .TAIL(TAIL)) u_seq (
    .clk (clk), .rst_n (rst_s),
    .e_arm (cmd_rise[0]), .e_abort (cmd_rise[2]), .e_reset (cmd_rise[3]),
    .fire (fire), .mode_err (cfg_err_mode), .stop_on_err (cfg_stop_on_err),
    .err_in (err_flag), .post_len (post_len),
    .state (st), .wr_en (wr_en), .wr_addr (wr_addr),
    .trig_pos (trig_addr), .word_cnt (word_count), .armed (armed)
  );

  tcs_mem #(.AW(AW), .DW(DW)) u_mem (
    .clk (clk), .rst_n (rst_s), .wr_en (wr_en), .wr_addr (wr_addr),
    .wr_data (rx_word), .rd_addr (rd_addr), .rd_data (rd_data)
  );

  assign seq_state = st;
endmodule

// File: tb/trace_capture_seq_tb.sv
`timescale 1ns/1ps
module trace_capture_seq_tb;
  logic        clk = 1'b0;
  logic        rst_n;
  logic [35:0] rx_word;
  logic        ext_trig, cfg_err_mode, cfg_stop_on_err;
  logic [36:0] trig_pat, trig_mask;
  logic [10:0] post_len, rd_addr, trig_addr;
  logic        cmd_arm, cmd_force, cmd_abort, cmd_reset, err_flag;
  logic [35:0] rd_data;
  logic [1:0]  seq_state;
  logic [47:0] word_count;

  int checks = 0;
  int errors = 0;
  int bptr   = 0;
  logic [35:0] exp_mem [2048];

  always #2.5 clk = ~clk;

  trace_capture_seq u_dut (
    .clk(clk), .rst_n(rst_n), .rx_word(rx_word), .ext_trig(ext_trig),
    .cfg_err_mode(cfg_err_mode), .cfg_stop_on_err(cfg_stop_on_err),
    .trig_pat(trig_pat), .trig_mask(trig_mask), .post_len(post_len),
    .cmd_arm(cmd_arm), .cmd_force(cmd_force), .cmd_abort(cmd_abort),
    .cmd_reset(cmd_reset), .err_flag(err_flag), .rd_addr(rd_addr),
    .rd_data(rd_data), .seq_state(seq_state), .trig_addr(trig_addr),
    .word_count(word_count)
  );

  function automatic logic [35:0] rnd36();
    return {4'($urandom), 32'($urandom)};
  endfunction

  task automatic chk(input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic tick();
    @(posedge clk);
    @(negedge clk);
  endtask

  task automatic cyc(input logic [35:0] w, input logic e, input bit wr);
    rx_word  = w;
    ext_trig = e;
    if (wr) begin
      exp_mem[bptr] = w;
      bptr = (bptr + 1) % 2048;
    end
    tick();
  endtask

  task automatic do_sreset();
    cmd_reset = 1'b1; tick();
    cmd_reset = 1'b0; tick();
  endtask

  task automatic do_arm();
    cmd_arm = 1'b1; tick();
    cmd_arm = 1'b0;
    bptr = 0;
  endtask

  // kind 0: external bit must be 1; kind 1: 32 data bits must match
  task automatic set_pattern(input int kind);
    if (kind == 1) begin
      trig_pat  = {1'b0, rnd36()};
      trig_mask = {1'b1, 4'hF, 32'h0};
    end else begin
      trig_pat  = {1'b1, rnd36()};
      trig_mask = {1'b0, {36{1'b1}}};
    end
  endtask

  task automatic chk_mem(input string req, input int base, input int n);
    bit bad = 0;
    logic [35:0] ga = '0, ge = '0;
    for (int i = 0; i < n; i++) begin
      rd_addr = 11'((base + i) % 2048);
      tick();
      if (!bad && rd_data !== exp_mem[(base + i) % 2048]) begin
        bad = 1; ga = rd_data; ge = exp_mem[(base + i) % 2048];
      end
    end
    if (bad) chk(req, 64'(ga), 64'(ge));
    else     chk(req, 64'(rd_data), 64'(rd_data));
  endtask

  // kind 0 external trigger, 1 data pattern, 2 force
  task automatic run_rec(input int n, input int pre, input int kind);
    int neff, tp;
    logic [35:0] tw;
    do_sreset();
    cfg_err_mode = 1'b0; cfg_stop_on_err = 1'b0;
    post_len = 11'(n);
    set_pattern(kind);
    do_arm();
    neff = (n < 2) ? 2 : n;
    for (int i = 0; i < pre; i++) cyc(rnd36(), 1'b0, 1);
    tp = bptr;
    if (kind == 1) begin
      tw = (trig_pat[35:0] & ~trig_mask[35:0]) | (rnd36() & trig_mask[35:0]);
      cyc(tw, 1'b0, 1);                       // R3 don't-care bits randomised
    end else if (kind == 2) begin
      cmd_force = 1'b1;
      cyc(rnd36(), 1'b0, 1);                  // R4
      cmd_force = 1'b0;
    end else begin
      cyc(rnd36(), 1'b1, 1);                  // R3 external bit
    end
    for (int i = 1; i < neff; i++) begin
      if (i == neff - 1) chk("R6 not stopped before last word", 64'(seq_state == 2'd3), 64'd0);
      cyc(rnd36(), 1'b0, 1);
    end
    chk("R6 stopped after N words", 64'(seq_state), 64'd3);
    chk("R5 trigger address", 64'(trig_addr), 64'(tp));
    chk("R7 word count equals N", 64'(word_count), 64'(neff));
    for (int i = 0; i < 4; i++) cyc(rnd36(), 1'b1, 0);
    chk("R7 count frozen in stop", 64'(word_count), 64'(neff));
    chk_mem("R12 trace contents", 0, bptr);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    int m;
    logic [35:0] keep;
    void'($urandom(32'd20240917));
    rst_n = 1'b0; rx_word = '0; ext_trig = 0; cfg_err_mode = 0; cfg_stop_on_err = 0;
    trig_pat = '0; trig_mask = '1; post_len = 11'd1024; cmd_arm = 0; cmd_force = 0;
    cmd_abort = 0; cmd_reset = 0; err_flag = 0; rd_addr = '0;
    repeat (3) tick();
    rst_n = 1'b1;
    repeat (3) tick();
    chk("R1 reset state", 64'(seq_state), 64'd0);
    chk("R1 reset count", 64'(word_count), 64'd0);
    chk("R1 reset trigger address", 64'(trig_addr), 64'd0);

    run_rec(2, 5, 0);      // R6 minimum
    run_rec(0, 3, 1);      // R6 below minimum acts as 2
    run_rec(2047, 0, 0);   // R6 maximum, trigger on first armed word
    run_rec(3, 7, 2);
    for (int k = 0; k < 6; k++)
      run_rec(3 + int'($urandom % 1200), int'($urandom % 300), int'($urandom % 3));

    // R11 soft reset keeps memory
    keep = exp_mem[0];
    do_sreset();
    chk("R11 state idle", 64'(seq_state), 64'd0);
    chk("R11 count cleared", 64'(word_count), 64'd0);
    chk("R11 trigger address cleared", 64'(trig_addr), 64'd0);
    rd_addr = 11'd0; tick();
    chk("R11 memory kept", 64'(rd_data), 64'(keep));

    // R2 arm, R10 abort from armed, R2 arm ignored when stopped
    set_pattern(0);
    do_arm();
    chk("R2 armed", 64'(seq_state), 64'd1);
    cmd_abort = 1'b1; tick(); cmd_abort = 1'b0;
    chk("R10 abort from armed", 64'(seq_state), 64'd3);
    chk("R10 count zero after abort", 64'(word_count), 64'd0);
    cmd_arm = 1'b1; tick(); tick(); cmd_arm = 1'b0;
    chk("R2 arm ignored when stopped", 64'(seq_state), 64'd3);

    // R4 held force level does not retrigger
    do_sreset();
    cmd_force = 1'b1; tick();
    do_arm();
    for (int i = 0; i < 10; i++) cyc(rnd36(), 1'b0, 1);
    chk("R4 held force acts once", 64'(seq_state), 64'd1);
    chk("R7 no count while armed", 64'(word_count), 64'd0);
    cmd_force = 1'b0;

    // R10 collision: abort meets the registered trigger decision
    do_sreset();
    cfg_err_mode = 1'b0; post_len = 11'd100; set_pattern(0);
    do_arm();
    for (int i = 0; i < 4; i++) cyc(rnd36(), 1'b0, 1);
    cyc(rnd36(), 1'b1, 1);
    cmd_abort = 1'b1;
    cyc(rnd36(), 1'b0, 1);
    cmd_abort = 1'b0;
    chk("R10 abort wins state", 64'(seq_state), 64'd3);
    chk("R10 abort wins count", 64'(word_count), 64'd0);
    chk("R10 abort wins trigger address", 64'(trig_addr), 64'd0);

    // R8 error mode wraps, then abort from running
    do_sreset();
    cfg_err_mode = 1'b1; cfg_stop_on_err = 1'b0; set_pattern(0);
    do_arm();
    for (int i = 0; i < 3; i++) cyc(rnd36(), 1'b0, 1);
    cyc(rnd36(), 1'b1, 1);
    for (int i = 0; i < 2100; i++) cyc(rnd36(), 1'b1, 1);
    chk("R8 still running past depth", 64'(seq_state), 64'd2);
    cmd_abort = 1'b1;
    cyc(rnd36(), 1'b0, 1);
    cmd_abort = 1'b0;
    chk("R10 abort from running", 64'(seq_state), 64'd3);
    chk("R8 count across wrap", 64'(word_count), 64'd2102);
    chk("R5 trigger address error mode", 64'(trig_addr), 64'd3);
    chk_mem("R8 wrapped trace contents", 0, 2048);

    // R9 stop on error after a 15-word tail
    do_sreset();
    cfg_err_mode = 1'b1; cfg_stop_on_err = 1'b1; set_pattern(0);
    do_arm();
    for (int i = 0; i < 2; i++) cyc(rnd36(), 1'b0, 1);
    cyc(rnd36(), 1'b1, 1);
    m = 1 + int'($urandom % 40);
    for (int i = 0; i < m; i++) cyc(rnd36(), 1'b0, 1);
    err_flag = 1'b1;
    cyc(rnd36(), 1'b0, 1);
    err_flag = 1'b0;
    for (int i = 0; i < 14; i++) cyc(rnd36(), 1'b0, 1);
    chk("R9 running through tail", 64'(seq_state), 64'd2);
    cyc(rnd36(), 1'b0, 1);
    chk("R9 stopped after tail", 64'(seq_state), 64'd3);
    chk("R9 count includes tail", 64'(word_count), 64'(m + 17));
    for (int i = 0; i < 3; i++) cyc(rnd36(), 1'b0, 0);
    chk("R7 count frozen after error stop", 64'(word_count), 64'(m + 17));
    chk_mem("R9 tail words stored", 0, bptr);

    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule